// File: doc/BRIEF.md
# PWM Sample Feeder with Prefetch Word

This block sits between a DMA engine and one or two PWM channel generators. It holds 32-bit samples in a small word FIFO. One register stage, the prefetch word, sits between the FIFO head and the samples each channel is currently producing. Software or a DMA engine pushes samples through a single write port. The feeder raises a request level while the word count is strictly below a programmed threshold. This happens whether or not the channels are enabled, so the FIFO can fill ahead of time.

When the channels are enabled, the feeder loads the active samples and then keeps the prefetch word filled. Each channel generator pulses a period-done strobe when it finishes a period, and the channel then takes its next sample from the prefetch word. Single-channel mode never stops: when supply runs out, the active sample simply repeats. Dual-channel mode hands words to channel 0 and channel 1 in turn. When a channel finds nothing for it, both channels halt and both gap flags latch, unless the hold option is set.

Top module: `pwm_sample_feed`

## Requirements
- R1: `dreq` is 1 exactly while the stored word count is strictly less than `dreq_level`, and this does not depend on `enable`. A level of 0 therefore never requests.
- R2: `empty` is 1 exactly while the FIFO stores no word.
- R3: The FIFO holds 8 words. A push while full is discarded and sets the sticky `wr_err` flag, which `err_clr` clears.
- R4: Single mode start: on the first clock edge with `enable`=1 and a non-empty FIFO, the head word becomes `sample0` and `running` becomes 01. On the next edge, a further word (if present) moves into the prefetch word.
- R5: In single mode, a `ch_done[0]` pulse moves the prefetch word into `sample0` on that edge. `ch_done[1]` and `repeat_last` have no effect.
- R6: In single mode, a `ch_done[0]` pulse with no prefetch word leaves `sample0` unchanged, `running[0]` at 1 and `gap` at 00.
- R7: Dual mode start: the first word goes to `sample0` (running 01) and, one edge later, the next word goes to `sample1` (running 11). Later words alternate, ch0 first.
- R8: In dual mode with `repeat_last`=0, a period-done pulse for a channel with no word queued for it clears `running` to 00 and sets `gap` to 11. The samples keep their values.
- R9: Each `gap` bit is sticky and clears only when 1 is written to its `gap_clr` bit.
- R10: In dual mode with `repeat_last`=1, a starved channel keeps its sample, and `running` stays 11 with no gap set.
- R11: With `enable`=0, `running` is 00 and any prefetch word is discarded. A later enable starts from the FIFO head.
- R12: The prefetch word refills from the FIFO on the edge after the edge on which it was handed to a channel, provided the FIFO is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Push strobe |
| wr_data | input | 32 | Sample word to push |
| err_clr | input | 1 | Clears `wr_err` |
| dreq_level | input | 4 | Request threshold in words |
| dreq | output | 1 | Request level, count < threshold |
| empty | output | 1 | FIFO holds no word |
| wr_err | output | 1 | Sticky: push was dropped while full |
| enable | input | 1 | Channels enabled |
| dual | input | 1 | Dual-channel mode, captured at start |
| repeat_last | input | 1 | Dual mode: hold the last sample instead of stopping |
| ch_done | input | 2 | Period-done strobes, bit per channel |
| gap_clr | input | 2 | Write 1 to clear a gap bit |
| sample0 | output | 32 | Active sample of channel 0 |
| sample1 | output | 32 | Active sample of channel 1 |
| running | output | 2 | Channel running bits |
| gap | output | 2 | Sticky gap flags |

## Verification
Flag results are due one edge after their cause: `empty`, `wr_err` and the count behind `dreq` change on the edge that takes the push. A sample handover appears one edge after the period-done strobe, and the prefetch refill happens on the following edge, which the count-driven `dreq` and `empty` make visible. Dual start needs one edge per channel. The bench drives every input just after a falling edge and holds it across exactly one rising edge. It samples at the next falling edge and inserts one idle cycle wherever a refill must land before the next strobe.

// File: rtl/pwm_feed_pkg.sv
`timescale 1ns/1ps
package pwm_feed_pkg;

    typedef enum logic [1:0] {
        FEED_IDLE  = 2'd0,
        FEED_LOAD1 = 2'd1,
        FEED_RUN   = 2'd2,
        FEED_HALT  = 2'd3
    } feed_state_e;

endpackage

// File: rtl/pwm_word_fifo.sv
`timescale 1ns/1ps
module pwm_word_fifo #(
    parameter  int DW    = 32,
    parameter  int DEPTH = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    input  logic          err_clr,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          wr_err
);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [AW-1:0]            wp;
        logic [AW-1:0]            rp;
        logic [CW-1:0]            cnt;
        logic                     err;
    } fifo_t;

    fifo_t q, d;
    logic  full, push_ok, pop_ok;

    always_comb begin
        d       = q;
        full    = (q.cnt == CW'(DEPTH));
        push_ok = push && !full;
        pop_ok  = pop && (q.cnt != '0);
        if (push_ok) begin
            d.mem[q.wp] = push_data;
            d.wp        = (q.wp == AW'(DEPTH - 1)) ? '0 : q.wp + AW'(1);
        end
        if (pop_ok) begin
            d.rp = (q.rp == AW'(DEPTH - 1)) ? '0 : q.rp + AW'(1);
        end
        case ({push_ok, pop_ok})
            2'b10:   d.cnt = q.cnt + CW'(1);
            2'b01:   d.cnt = q.cnt - CW'(1);
            default: d.cnt = q.cnt;
        endcase
        if (err_clr)      d.err = 1'b0;
        if (push && full) d.err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign head   = q.mem[q.rp];
    assign count  = q.cnt;
    assign wr_err = q.err;

    // R3: occupancy never exceeds the depth
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CW'(DEPTH));

    // R3: a push into a full FIFO without a pop leaves the count alone
    a_r3_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (push && (q.cnt == CW'(DEPTH)) && !pop) |=> $stable(q.cnt));

endmodule

// File: rtl/pwm_feed_ctrl.sv
`timescale 1ns/1ps
module pwm_feed_ctrl
    import pwm_feed_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          dual,
    input  logic          repeat_last,
    input  logic [1:0]    ch_done,
    input  logic [1:0]    gap_clr,
    input  logic          fifo_empty,
    input  logic [DW-1:0] fifo_head,
    output logic          fifo_pop,
    output logic [DW-1:0] sample0,
    output logic [DW-1:0] sample1,
    output logic [1:0]    running,
    output logic [1:0]    gap
);

    typedef struct packed {
        feed_state_e   st;
        logic          dual_m;
        logic          pf_valid;
        logic          pf_tag;
        logic          next_tag;
        logic [DW-1:0] pf_word;
        logic [DW-1:0] act0;
        logic [DW-1:0] act1;
        logic [1:0]    run;
        logic [1:0]    gap;
    } ctrl_t;

    ctrl_t q, d;
    logic  take0, take1, starve, have;

    always_comb begin
        d        = q;
        fifo_pop = 1'b0;
        take0    = 1'b0;
        take1    = 1'b0;
        starve   = 1'b0;
        have     = !fifo_empty;
        d.gap    = q.gap & ~gap_clr;
        if (!enable) begin
            d.st       = FEED_IDLE;
            d.run      = 2'b00;
            d.pf_valid = 1'b0;
        end else begin
            case (q.st)
                FEED_IDLE: begin
                    if (have) begin
                        fifo_pop   = 1'b1;
                        d.act0     = fifo_head;
                        d.run      = 2'b01;
                        d.dual_m   = dual;
                        d.next_tag = 1'b0;
                        d.st       = dual ? FEED_LOAD1 : FEED_RUN;
                    end
                end
                FEED_LOAD1: begin
                    if (have) begin
                        fifo_pop  = 1'b1;
                        d.act1    = fifo_head;
                        d.run[1]  = 1'b1;
                        d.st      = FEED_RUN;
                    end
                end
                FEED_RUN: begin
                    take0 = ch_done[0] && q.pf_valid && (!q.dual_m || !q.pf_tag);
                    if (take0) begin
                        d.act0     = q.pf_word;
                        d.pf_valid = 1'b0;
                    end else if (ch_done[0] && q.dual_m && !repeat_last) begin
                        starve = 1'b1;
                    end
                    if (q.dual_m) begin
                        take1 = ch_done[1] && q.pf_valid && q.pf_tag;
                        if (take1) begin
                            d.act1     = q.pf_word;
                            d.pf_valid = 1'b0;
                        end else if (ch_done[1] && !repeat_last) begin
                            starve = 1'b1;
                        end
                    end
                    if (starve) begin
                        d.st       = FEED_HALT;
                        d.run      = 2'b00;
                        d.gap      = d.gap | 2'b11;
                    end else if (!q.pf_valid && have) begin
                        fifo_pop   = 1'b1;
                        d.pf_word  = fifo_head;
                        d.pf_valid = 1'b1;
                        d.pf_tag   = q.next_tag;
                        d.next_tag = q.dual_m ? ~q.next_tag : 1'b0;
                    end
                end
                default: begin
                    d.run = 2'b00;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sample0 = q.act0;
    assign sample1 = q.act1;
    assign running = q.run;
    assign gap     = q.gap;

    // R6: single mode keeps channel 0 running while enabled
    a_r6_single_runs: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && q.st == FEED_RUN && !q.dual_m) |=> running[0]);

    // R8: dual starvation of channel 0 halts both and latches both gaps
    a_r8_dual_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && q.st == FEED_RUN && q.dual_m && !repeat_last && ch_done[0]
         && !(q.pf_valid && !q.pf_tag))
        |=> (running == 2'b00 && gap == 2'b11));

    // R12: an empty prefetch slot is refilled when words are waiting
    a_r12_refill: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && q.st == FEED_RUN && !q.dual_m && !q.pf_valid && !fifo_empty)
        |=> q.pf_valid);

endmodule

// File: rtl/pwm_sample_feed.sv
`timescale 1ns/1ps
module pwm_sample_feed #(
    parameter  int DW    = 32,
    parameter  int DEPTH = 8,
    localparam int CW    = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          err_clr,
    input  logic [CW-1:0] dreq_level,
    output logic          dreq,
    output logic          empty,
    output logic          wr_err,
    input  logic          enable,
    input  logic          dual,
    input  logic          repeat_last,
    input  logic [1:0]    ch_done,
    input  logic [1:0]    gap_clr,
    output logic [DW-1:0] sample0,
    output logic [DW-1:0] sample1,
    output logic [1:0]    running,
    output logic [1:0]    gap
);

    logic [DW-1:0] head;
    logic [CW-1:0] count;
    logic          pop;

    pwm_word_fifo #(.DW(DW), .DEPTH(DEPTH)) i_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_en),
        .push_data (wr_data),
        .pop       (pop),
        .err_clr   (err_clr),
        .head      (head),
        .count     (count),
        .wr_err    (wr_err)
    );

    pwm_feed_ctrl #(.DW(DW)) i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .dual        (dual),
        .repeat_last (repeat_last),
        .ch_done     (ch_done),
        .gap_clr     (gap_clr),
        .fifo_empty  (empty),
        .fifo_head   (head),
        .fifo_pop    (pop),
        .sample0     (sample0),
        .sample1     (sample1),
        .running     (running),
        .gap         (gap)
    );

    assign empty = (count == '0);
    assign dreq  = (count < dreq_level);

    // R2: the controller never pops while the FIFO reports empty
    a_r2_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: tb/test_pwm_sample_feed.sv
`timescale 1ns/1ps
module test_pwm_sample_feed;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        err_clr = 1'b0;
    logic [3:0]  dreq_level = '0;
    logic        dreq, empty, wr_err;
    logic        enable = 1'b0;
    logic        dual = 1'b0;
    logic        repeat_last = 1'b0;
    logic [1:0]  ch_done = '0;
    logic [1:0]  gap_clr = '0;
    logic [31:0] sample0, sample1;
    logic [1:0]  running, gap;

    int nchk = 0;
    int nerr = 0;
    bit finished = 0;
    logic [31:0] exp0_q[$];
    logic [31:0] exp1_q[$];

    always #2.5 clk = ~clk;

    pwm_sample_feed i_pwm_sample_feed (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .err_clr(err_clr), .dreq_level(dreq_level), .dreq(dreq),
        .empty(empty), .wr_err(wr_err), .enable(enable), .dual(dual),
        .repeat_last(repeat_last), .ch_done(ch_done), .gap_clr(gap_clr),
        .sample0(sample0), .sample1(sample1), .running(running), .gap(gap)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic push(input logic [31:0] v);
        wr_en = 1'b1; wr_data = v;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [1:0] m);
        ch_done = m;
        tick();
        ch_done = 2'b00;
    endtask

    // monitor side of the scoreboard: compare against the next expected item
    task automatic expect_s0(input string req);
        chk(req, sample0, exp0_q.pop_front());
    endtask

    task automatic expect_s1(input string req);
        chk(req, sample1, exp1_q.pop_front());
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick();
        // reset state
        chk("R2 empty at reset", 32'(empty), 32'd1);
        chk("R1 level 0 no request", 32'(dreq), 32'd0);
        chk("R11 running at reset", 32'(running), 32'd0);
        chk("R9 gap at reset", 32'(gap), 32'd0);
        chk("R3 wr_err at reset", 32'(wr_err), 32'd0);

        // R1 threshold compare, channels disabled
        dreq_level = 4'd3;
        tick();
        chk("R1 count0 < 3", 32'(dreq), 32'd1);
        push(32'hA000_0001); exp0_q.push_back(32'hA000_0001);
        chk("R2 not empty after push", 32'(empty), 32'd0);
        push(32'hA000_0002); exp0_q.push_back(32'hA000_0002);
        chk("R1 count2 < 3", 32'(dreq), 32'd1);
        push(32'hA000_0003); exp0_q.push_back(32'hA000_0003);
        chk("R1 count3 not < 3", 32'(dreq), 32'd0);
        dreq_level = 4'd0;
        tick();
        chk("R1 level 0 with words", 32'(dreq), 32'd0);

        // R4 single start: count 3 -> 2 -> 1 seen through dreq at level 2
        dreq_level = 4'd2;
        enable = 1'b1;
        tick();
        expect_s0("R4 first word to sample0");
        chk("R4 running", 32'(running), 32'd1);
        chk("R4 count2 after start", 32'(dreq), 32'd0);
        tick();
        chk("R4 prefetch took second word", 32'(dreq), 32'd1);

        // R5 handover, R12 refill
        pulse(2'b01);
        expect_s0("R5 prefetch to sample0");
        chk("R12 no refill on handover edge", 32'(empty), 32'd0);
        tick();
        chk("R12 refill emptied fifo", 32'(empty), 32'd1);
        pulse(2'b10);
        chk("R5 ch_done1 ignored s0", sample0, 32'hA000_0002);
        chk("R5 ch_done1 ignored s1", sample1, 32'h0);
        pulse(2'b01);
        expect_s0("R5 third word");
        // R6 starvation repeats
        pulse(2'b01);
        chk("R6 sample repeats", sample0, 32'hA000_0003);
        chk("R6 still running", 32'(running), 32'd1);
        chk("R6 no gap", 32'(gap), 32'd0);

        // R12 refill of a word arriving later
        push(32'hB000_0004);
        chk("R12 word waiting", 32'(empty), 32'd0);
        tick();
        chk("R12 word moved to prefetch", 32'(empty), 32'd1);
        pulse(2'b01);
        chk("R12 late word used", sample0, 32'hB000_0004);

        // R11 disable drops prefetch
        push(32'hDEAD_0005);
        tick();
        enable = 1'b0;
        tick();
        chk("R11 running cleared", 32'(running), 32'd0);
        push(32'hC000_0006);
        enable = 1'b1;
        tick();
        chk("R11 restart from head", sample0, 32'hC000_0006);
        tick();
        enable = 1'b0;
        tick();

        // R3 overflow
        for (int i = 0; i < 8; i++) begin
            push(32'h5700_0000 + 32'(i));
            if (i % 2 == 0) exp0_q.push_back(32'h5700_0000 + 32'(i));
            else            exp1_q.push_back(32'h5700_0000 + 32'(i));
        end
        chk("R3 no error at full", 32'(wr_err), 32'd0);
        push(32'h5700_0008);
        chk("R3 error on overflow", 32'(wr_err), 32'd1);
        tick();
        chk("R3 error sticky", 32'(wr_err), 32'd1);
        err_clr = 1'b1;
        tick();
        err_clr = 1'b0;
        chk("R3 error cleared", 32'(wr_err), 32'd0);

        // R7 dual start and alternation
        dual = 1'b1;
        enable = 1'b1;
        tick();
        expect_s0("R7 ch0 first word");
        chk("R7 running 01", 32'(running), 32'd1);
        tick();
        expect_s1("R7 ch1 second word");
        chk("R7 running 11", 32'(running), 32'd3);
        tick();
        for (int k = 0; k < 3; k++) begin
            pulse(2'b01);
            expect_s0("R7 ch0 alternate");
            tick();
            pulse(2'b10);
            expect_s1("R7 ch1 alternate");
            tick();
        end
        // R8 dual starvation (dropped overflow word must not appear)
        pulse(2'b01);
        chk("R8 running cleared", 32'(running), 32'd0);
        chk("R8 both gaps", 32'(gap), 32'd3);
        chk("R8 sample0 kept", sample0, 32'h5700_0006);
        chk("R3 dropped word absent", 32'(empty), 32'd1);

        // R9 write-1-to-clear
        tick();
        chk("R9 gap sticky", 32'(gap), 32'd3);
        gap_clr = 2'b01;
        tick();
        gap_clr = 2'b00;
        chk("R9 clear bit0", 32'(gap), 32'd2);
        gap_clr = 2'b10;
        tick();
        gap_clr = 2'b00;
        chk("R9 clear bit1", 32'(gap), 32'd0);

        // R10 dual hold
        enable = 1'b0;
        tick();
        push(32'hE000_0010);
        push(32'hE000_0011);
        repeat_last = 1'b1;
        enable = 1'b1;
        tick(); tick(); tick();
        pulse(2'b01);
        chk("R10 sample0 held", sample0, 32'hE000_0010);
        chk("R10 still running", 32'(running), 32'd3);
        chk("R10 no gap", 32'(gap), 32'd0);
        pulse(2'b10);
        chk("R10 sample1 held", sample1, 32'hE000_0011);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule